// File: doc/BRIEF.md
# Literal-Select Execute Stage

This block is the execute stage of a small 8-bit processor. Each instruction arrives as four bytes: an operation byte, two source bytes and a destination byte. The two top bits of the operation byte decide, each on its own, whether a source byte is a register number or the operand value itself. The low six bits pick the operation. The stage reads its operands, computes the result and writes it back, all in the clock cycle in which `instr_valid` is high.

The register space has eight addresses. Addresses 0 to 5 are general registers, and register 5 also holds the data-memory address. Address 6 is the program counter, so a result written there is a jump. Address 7 is the I/O port: a read returns `io_in` and a write sets `io_out`. A small internal data memory serves the store and load operations.

Top module: `lit_alu_stage`

## Requirements
- R1: After reset `pc` and `io_out` are 0 and general registers 0 to 5 read as 0. The reset input is asynchronous and active low, and it is released synchronously after two clock edges.
- R2: Operation-byte bit 7 makes source A a literal value. Bit 6 does the same for source B. When a bit is clear, the low 3 bits of that source byte select a register. Both bits are removed before the operation is decoded.
- R3: The operation code is the low 6 bits of the operation byte. The codes are 0 A+B, 1 A−B, 2 A AND B, 3 A OR B, 4 NOT A (bitwise), 5 A XOR B, 6 A shifted right by B, 7 A shifted left by B, and 10 the low 8 bits of A×B. All results wrap modulo 256. A shift by 8 or more gives 0.
- R4: The low 3 bits of the destination byte give the target register, and bits 7:3 are ignored. A result aimed at address 0 to 5 is stored in that general register.
- R5: A result written to address 6 loads `pc` with the result. Any other accepted instruction adds 4 to `pc`, modulo 256.
- R6: Reading address 7 returns `io_in`. Writing address 7 sets `io_out`, which then holds its value until the next write to address 7.
- R7: Reading address 6 returns the `pc` value from before the instruction executes.
- R8: Code 8 stores operand A at data-memory word `r5 mod MEM_DEPTH` (16 by default) and writes no register. Code 9 loads that word into the destination.
- R9: While `instr_valid` is low, `pc`, `io_out` and all registers and memory keep their values.
- R10: Codes 11 to 63 write nothing and only add 4 to `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Execute the presented instruction at this edge |
| instr_op | input | 8 | Operation byte: bit 7 A literal, bit 6 B literal, bits 5:0 code |
| instr_src_a | input | 8 | Source A: register number or literal |
| instr_src_b | input | 8 | Source B: register number or literal |
| instr_dst | input | 8 | Destination register number (low 3 bits) |
| io_in | input | 8 | Value returned when address 7 is read |
| io_out | output | 8 | Last value written to address 7 |
| pc | output | 8 | Program counter |

## Verification
Every result is due at the first rising edge that samples `instr_valid` high. At that edge `io_out`, `pc`, the destination register and the memory word all change together. A general register's value can only be observed by a second instruction that copies it to address 7, so its value appears one edge later. The bench drives each instruction on a falling edge and compares the outputs on the next falling edge. That comparison falls half a period after the edge that made the change, so it never competes with the edge. The bench waits three falling edges after it releases reset, to cover the two-stage reset release.

// File: rtl/lit_alu_pkg.sv
package lit_alu_pkg;

  typedef enum logic [5:0] {
    OP_ADD   = 6'd0,
    OP_SUB   = 6'd1,
    OP_AND   = 6'd2,
    OP_OR    = 6'd3,
    OP_NOT   = 6'd4,
    OP_XOR   = 6'd5,
    OP_SHR   = 6'd6,
    OP_SHL   = 6'd7,
    OP_STORE = 6'd8,
    OP_LOAD  = 6'd9,
    OP_MUL   = 6'd10
  } op_code_e;

  localparam int unsigned REG_AW  = 3;
  localparam int unsigned NUM_GPR = 6;

  localparam logic [REG_AW-1:0] ADDR_PTR = 3'd5;
  localparam logic [REG_AW-1:0] ADDR_PC  = 3'd6;
  localparam logic [REG_AW-1:0] ADDR_IO  = 3'd7;

endpackage

// File: rtl/lit_alu_core.sv
module lit_alu_core
  import lit_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [5:0]    code,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  output logic [DW-1:0] result,
  output logic          is_alu
);

  logic [2*DW-1:0] product;

  always_comb begin
    product = {{DW{1'b0}}, opnd_a} * {{DW{1'b0}}, opnd_b};
  end

  always_comb begin
    result = '0;
    is_alu = 1'b1;
    case (code)
      OP_ADD: result = opnd_a + opnd_b;
      OP_SUB: result = opnd_a - opnd_b;
      OP_AND: result = opnd_a & opnd_b;
      OP_OR:  result = opnd_a | opnd_b;
      OP_NOT: result = ~opnd_a;
      OP_XOR: result = opnd_a ^ opnd_b;
      OP_SHR: result = opnd_a >> opnd_b;
      OP_SHL: result = opnd_a << opnd_b;
      OP_MUL: result = product[DW-1:0];
      default: is_alu = 1'b0;
    endcase
  end

  logic unused_prod_hi;
  assign unused_prod_hi = ^product[2*DW-1:DW];

endmodule

// File: rtl/lit_alu_dmem.sv
module lit_alu_dmem #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [DW-1:0] ptr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);

  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [IW-1:0] idx;

  assign idx     = ptr[IW-1:0];
  assign rd_data = mem_q[idx];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[idx] <= wr_data;
    end
  end

  generate
    if (DW > IW) begin : g_unused_hi
      logic unused_ptr_hi;
      assign unused_ptr_hi = ^ptr[DW-1:IW];
    end
  endgenerate

endmodule

// File: rtl/lit_alu_regs.sv
module lit_alu_regs
  import lit_alu_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [REG_AW-1:0] rd_a_addr,
  input  logic [REG_AW-1:0] rd_b_addr,
  output logic [DW-1:0]     rd_a_data,
  output logic [DW-1:0]     rd_b_data,
  output logic [DW-1:0]     ptr,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [DW-1:0]     io_in,
  output logic [DW-1:0]     pc,
  output logic [DW-1:0]     io_out
);

  localparam int unsigned FLAT_W = NUM_GPR * DW;

  logic [FLAT_W-1:0] gpr_flat;

  generate
    for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
      logic          hit;
      logic [DW-1:0] q_r;
      assign hit = wr_en && (wr_addr == REG_AW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q_r <= '0;
        end else if (hit) begin
          q_r <= wr_data;
        end
      end
      assign gpr_flat[g*DW +: DW] = q_r;
    end
  endgenerate

  logic [DW-1:0] pc_q, pc_d, io_q;
  logic          jump, io_en;

  always_comb begin
    jump  = wr_en && (wr_addr == ADDR_PC);
    io_en = wr_en && (wr_addr == ADDR_IO);
    pc_d  = jump ? wr_data : (pc_q + DW'(PC_STEP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (fire) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_q <= '0;
    end else if (io_en) begin
      io_q <= wr_data;
    end
  end

  always_comb begin
    case (rd_a_addr)
      ADDR_PC: rd_a_data = pc_q;
      ADDR_IO: rd_a_data = io_in;
      default: rd_a_data = gpr_flat[rd_a_addr*DW +: DW];
    endcase
    case (rd_b_addr)
      ADDR_PC: rd_b_data = pc_q;
      ADDR_IO: rd_b_data = io_in;
      default: rd_b_data = gpr_flat[rd_b_addr*DW +: DW];
    endcase
  end

  assign ptr    = gpr_flat[ADDR_PTR*DW +: DW];
  assign pc     = pc_q;
  assign io_out = io_q;

  // R5
  pc_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_en && wr_addr == ADDR_PC) |=> (pc == $past(wr_data)));

  // R6
  io_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_IO) |=> (io_out == $past(wr_data)));

endmodule

// File: rtl/lit_alu_stage.sv
module lit_alu_stage
  import lit_alu_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned MEM_DEPTH = 16,
  parameter int unsigned PC_STEP   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [7:0]    instr_op,
  input  logic [DW-1:0] instr_src_a,
  input  logic [DW-1:0] instr_src_b,
  input  logic [DW-1:0] instr_dst,
  input  logic [DW-1:0] io_in,
  output logic [DW-1:0] io_out,
  output logic [DW-1:0] pc
);

  // reset: asserted at once, released after two edges
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [5:0]        code;
  logic              a_lit, b_lit;
  logic [REG_AW-1:0] dst;
  logic [DW-1:0]     rd_a_data, rd_b_data, opnd_a, opnd_b;
  logic [DW-1:0]     alu_result, mem_rdata, ptr, wr_data;
  logic              is_alu, wr_en, mem_we;

  always_comb begin
    code   = instr_op[5:0];
    a_lit  = instr_op[7];
    b_lit  = instr_op[6];
    dst    = instr_dst[REG_AW-1:0];
    opnd_a = a_lit ? instr_src_a : rd_a_data;
    opnd_b = b_lit ? instr_src_b : rd_b_data;
  end

  lit_alu_core #(.DW(DW)) alu_i (
    .code   (code),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .result (alu_result),
    .is_alu (is_alu)
  );

  always_comb begin
    wr_en   = instr_valid && (is_alu || code == OP_LOAD);
    wr_data = (code == OP_LOAD) ? mem_rdata : alu_result;
    mem_we  = instr_valid && (code == OP_STORE);
  end

  lit_alu_regs #(.DW(DW), .PC_STEP(PC_STEP)) regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fire      (instr_valid),
    .rd_a_addr (instr_src_a[REG_AW-1:0]),
    .rd_b_addr (instr_src_b[REG_AW-1:0]),
    .rd_a_data (rd_a_data),
    .rd_b_data (rd_b_data),
    .ptr       (ptr),
    .wr_en     (wr_en),
    .wr_addr   (dst),
    .wr_data   (wr_data),
    .io_in     (io_in),
    .pc        (pc),
    .io_out    (io_out)
  );

  lit_alu_dmem #(.DW(DW), .DEPTH(MEM_DEPTH)) dmem_i (
    .clk     (clk),
    .wr_en   (mem_we),
    .ptr     (ptr),
    .wr_data (opnd_a),
    .rd_data (mem_rdata)
  );

  logic unused_dst_hi;
  assign unused_dst_hi = ^instr_dst[DW-1:REG_AW];

  // R5
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_valid && !(wr_en && dst == ADDR_PC)) |=> (pc == $past(pc) + DW'(PC_STEP)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !instr_valid |=> ($stable(pc) && $stable(io_out)));

  // R8
  store_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_valid && code == OP_STORE) |=> $stable(io_out));

  // R2
  lit_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_valid && a_lit && b_lit && code == OP_ADD && instr_src_b == '0 && dst == ADDR_IO)
      |=> (io_out == $past(instr_src_a)));

endmodule

// File: tb/lit_alu_stage_tb.sv
module lit_alu_stage_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       instr_valid;
  logic [7:0] instr_op, instr_src_a, instr_src_b, instr_dst, io_in;
  logic [7:0] io_out, pc;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] m_gpr [6];
  logic [7:0] m_mem [16];
  logic [7:0] m_pc, m_io;

  always #(CLK_PERIOD/2) clk = ~clk;

  lit_alu_stage dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_op    (instr_op),
    .instr_src_a (instr_src_a),
    .instr_src_b (instr_src_b),
    .instr_dst   (instr_dst),
    .io_in       (io_in),
    .io_out      (io_out),
    .pc          (pc)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_op(input logic [5:0] c, input logic [7:0] a, input logic [7:0] b);
    int prod;
    case (c)
      6'd0: return a + b;
      6'd1: return a - b;
      6'd2: return a & b;
      6'd3: return a | b;
      6'd4: return ~a;
      6'd5: return a ^ b;
      6'd6: return (b >= 8'd8) ? 8'd0 : (a >> b);
      6'd7: return (b >= 8'd8) ? 8'd0 : (a << b);
      6'd10: begin
        prod = int'(a) * int'(b);
        return prod[7:0];
      end
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] ad);
    if (ad == 3'd6) return m_pc;
    if (ad == 3'd7) return io_in;
    return m_gpr[ad];
  endfunction

  // call at a falling edge; returns at the next falling edge
  task automatic issue(input logic [7:0] op, input logic [7:0] sa,
                       input logic [7:0] sb, input logic [7:0] sd);
    logic [7:0] va, vb, res;
    logic       wr;
    va  = op[7] ? sa : m_read(sa[2:0]);
    vb  = op[6] ? sb : m_read(sb[2:0]);
    wr  = 1'b1;
    res = 8'd0;
    case (op[5:0])
      6'd0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 6'd10: res = ref_op(op[5:0], va, vb);
      6'd9: res = m_mem[m_gpr[5][3:0]];
      6'd8: begin
        m_mem[m_gpr[5][3:0]] = va;
        wr = 1'b0;
      end
      default: wr = 1'b0;
    endcase
    instr_valid = 1'b1;
    instr_op    = op;
    instr_src_a = sa;
    instr_src_b = sb;
    instr_dst   = sd;
    @(negedge clk);
    instr_valid = 1'b0;
    if (wr && sd[2:0] == 3'd6) m_pc = res;
    else m_pc = m_pc + 8'd4;
    if (wr && sd[2:0] == 3'd7) m_io = res;
    if (wr && sd[2:0] < 3'd6) m_gpr[sd[2:0]] = res;
  endtask

  task automatic show_reg(input logic [2:0] r);
    issue(8'h40, {5'd0, r}, 8'd0, 8'd7);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    logic [7:0] p0, io0, a, b;
    rst_n = 1'b0;
    instr_valid = 1'b0;
    instr_op = 8'd0; instr_src_a = 8'd0; instr_src_b = 8'd0; instr_dst = 8'd0;
    io_in = 8'h00;
    for (int k = 0; k < 6; k++) m_gpr[k] = 8'd0;
    for (int k = 0; k < 16; k++) m_mem[k] = 8'd0;
    m_pc = 8'd0; m_io = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 pc", pc, 8'd0);
    chk("R1 io_out", io_out, 8'd0);
    for (int r = 0; r < 6; r++) begin
      show_reg(3'(r));
      chk("R1 gpr", io_out, 8'd0);
    end

    // R4 register write and ignored upper destination bits
    issue(8'hC0, 8'h5A, 8'd0, 8'd3);
    show_reg(3'd3);
    chk("R4 gpr3", io_out, 8'h5A);
    issue(8'hC0, 8'h21, 8'd0, 8'hFC);
    show_reg(3'd4);
    chk("R4 dst hi ignored", io_out, 8'h21);

    // R6 input read and output hold
    io_in = 8'h3C;
    issue(8'h40, 8'd7, 8'd0, 8'd2);
    io0 = io_out;
    issue(8'hC0, 8'h11, 8'd0, 8'd1);
    chk("R6 io_out held", io_out, io0);
    show_reg(3'd2);
    chk("R6 io_in read", io_out, 8'h3C);

    // R7 pc read
    p0 = pc;
    issue(8'h40, 8'd6, 8'd0, 8'd7);
    chk("R7 pc read", io_out, p0);

    // R5 step, jump and wrap
    p0 = pc;
    issue(8'hC0, 8'h01, 8'd0, 8'd0);
    chk("R5 step", pc, p0 + 8'd4);
    issue(8'hC0, 8'h80, 8'd0, 8'd6);
    chk("R5 jump", pc, 8'h80);
    issue(8'hC0, 8'hFE, 8'd0, 8'd6);
    issue(8'hC0, 8'h02, 8'd0, 8'd0);
    chk("R5 wrap", pc, 8'h02);

    // R8 store, alias and load
    issue(8'hC0, 8'd3, 8'd0, 8'd5);
    io0 = io_out;
    issue(8'h88, 8'h77, 8'd0, 8'd7);
    chk("R8 store leaves io", io_out, io0);
    issue(8'hC0, 8'd19, 8'd0, 8'd5);
    issue(8'h09, 8'd0, 8'd0, 8'd7);
    chk("R8 load aliased", io_out, 8'h77);
    issue(8'hC0, 8'd4, 8'd0, 8'd5);
    issue(8'h08, 8'd3, 8'd0, 8'd0);
    issue(8'h09, 8'd0, 8'd0, 8'd0);
    show_reg(3'd0);
    chk("R8 store reg operand", io_out, 8'h5A);

    // R9 idle cycles with garbage fields
    p0 = pc; io0 = io_out;
    instr_op = 8'hC0; instr_src_a = 8'h99; instr_src_b = 8'd0; instr_dst = 8'd7;
    repeat (4) @(negedge clk);
    chk("R9 pc idle", pc, p0);
    chk("R9 io idle", io_out, io0);
    show_reg(3'd3);
    chk("R9 gpr idle", io_out, 8'h5A);

    // R10 unused codes
    p0 = pc; io0 = io_out;
    issue(8'hCB, 8'hEE, 8'd0, 8'd7);
    chk("R10 code11 io", io_out, io0);
    chk("R10 code11 pc", pc, p0 + 8'd4);
    issue(8'hFF, 8'hEE, 8'd0, 8'd6);
    chk("R10 code63 pc", pc, p0 + 8'd8);

    // R2 R3 sweep over codes, operands and literal selections
    for (int oi = 0; oi < 9; oi++) begin
      logic [5:0] c;
      c = (oi == 8) ? 6'd10 : 6'(oi);
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          a = 8'(i * 37 + 5);
          b = (j < 10) ? 8'(j) : 8'(j * 61 + 7);
          for (int cb = 0; cb < 4; cb++) begin
            logic la, lb;
            la = cb[1];
            lb = cb[0];
            if (!la) issue(8'hC0, a, 8'd0, 8'd1);
            if (!lb) issue(8'hC0, b, 8'd0, 8'd2);
            issue({la, lb, c}, la ? a : 8'd1, lb ? b : 8'd2, 8'd7);
            if (la && lb) chk("R3 literal ops", io_out, ref_op(c, a, b));
            else chk("R2 register operand", io_out, ref_op(c, a, b));
          end
        end
      end
      chk("R5 pc after sweep", pc, m_pc);
    end

    chk("R6 final io model", io_out, m_io);
    finish_run();
  end

endmodule